// File: doc/BRIEF.md
# Line-Synchronous Clamp and Sync Generator

This block sits in the pixel clock domain behind a raw horizontal sync input and produces two timing pulses for each video line. The first is a clamp window, which opens a programmed number of pixel periods after the trailing edge of the sync pulse and stays open for a programmed number of pixel periods. The second is a regenerated sync pulse of programmed width that starts from the leading edge. An external clamp input can replace the internal window.

The block must know which sync edge leads. That edge can be forced by a user polarity bit, or the block can work it out by itself. In the automatic case it compares how long the synchronized input spends at each level over a line and treats the shorter level as the active pulse. The raw sync passes through a two-flop synchronizer and a registered edge detector. All numeric configuration and the clamp-source select are captured once per line, on the leading edge, so changes made in the middle of a line take effect from the next line.

Top module: `line_clamp_sync`

## Requirements
- R1: The regenerated sync output goes high after the third rising clock edge that follows the edge which first samples the leading transition of `hsyncIn` (two synchronizer stages plus one registered edge strobe).
- R2: Once started, `syncOut` stays high for exactly `syncWidth` clock cycles. A `syncWidth` of 0 produces no pulse.
- R3: With the internal clamp selected, `clampOut` goes high P clock edges after the edge that acts on the trailing-edge strobe, where P is `clampPlace`. It stays high for `clampDur` cycles. The edge that acts on the strobe is the third edge after the trailing transition is first sampled.
- R4: A `clampPlace` of 0 acts as 1. A `clampDur` of 0 produces no clamp pulse.
- R5: When `clampExtSel` = 1 is captured at a leading edge, `clampOut` equals `extClampIn` combinationally until a leading edge captures 0, after which the internal window drives `clampOut` again.
- R6: With `polOverride` = 1, `polUser` = 1 makes the rising edge the leading edge and `polUser` = 0 makes the falling edge the leading edge. The non-leading edge never starts a sync pulse.
- R7: With `polOverride` = 0, the automatic polarity is used. The automatic polarity is evaluated at each synchronized rising edge: it is 1 (active high) when the line spent fewer cycles high than low, and 0 otherwise. `polDetected` changes only when two consecutive evaluations agree.
- R8: During and directly after reset, `clampOut` and `syncOut` are 0 and `polDetected` is 1.
- R9: A leading edge that arrives while a sync pulse is still running restarts the width count from that edge.
- R10: `clampPlace`, `clampDur`, `syncWidth` and `clampExtSel` are captured only at a leading edge. Changing them later in the line does not alter that line's pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low asynchronous reset |
| hsyncIn | input | 1 | Raw horizontal sync, asynchronous |
| extClampIn | input | 1 | External clamp request |
| clampPlace | input | 8 | Pixel periods from the trailing edge to clamp start |
| clampDur | input | 8 | Clamp length in pixel periods |
| syncWidth | input | 8 | Regenerated sync width in pixel periods |
| clampExtSel | input | 1 | 1 selects the external clamp |
| polOverride | input | 1 | 1 uses polUser, 0 uses automatic detection |
| polUser | input | 1 | User polarity, 1 active high |
| clampOut | output | 1 | Clamp window |
| syncOut | output | 1 | Regenerated sync pulse |
| polDetected | output | 1 | Automatically detected polarity, 1 active high |

## Verification
On every cycle the assertions check three things: a regenerated sync pulse starts only from a leading strobe, a zero width or zero duration captured at a leading edge suppresses the matching pulse, and a captured external select makes the clamp track its input. Only the bench scenarios show the rest. These are the exact pixel offsets of the clamp window after the trailing edge, the placement-zero alias, the restart of a running width count, mid-line configuration changes having no effect, and the two-line agreement rule of automatic polarity detection.

// File: rtl/lcs_pkg.sv
package lcs_pkg;
  typedef struct packed {
    logic lead;
    logic trail;
  } edgeStrobe_t;
endpackage

// File: rtl/lcs_sync_ctrl.sv
module lcs_sync_ctrl
  import lcs_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int LINE_CNT_W  = 12
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hsyncIn,
  input  logic        polOverride,
  input  logic        polUser,
  output edgeStrobe_t strobe,
  output logic        polDetected
);
  localparam logic [LINE_CNT_W-1:0] CNT_MAX = '1;

  logic [SYNC_STAGES-1:0] syncPipe;
  logic syncLvl, syncLvlQ, riseC, fallC, polHighEff;
  logic [LINE_CNT_W-1:0] highCnt, lowCnt;
  logic autoPol, lastCand, lineCand;

  // metastability chain
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncPipe <= '0;
    else       syncPipe <= {syncPipe[SYNC_STAGES-2:0], hsyncIn};
  end

  assign syncLvl = syncPipe[SYNC_STAGES-1];
  assign riseC   = syncLvl & ~syncLvlQ;
  assign fallC   = ~syncLvl & syncLvlQ;

  assign polHighEff = polOverride ? polUser : autoPol;
  assign lineCand   = (highCnt < lowCnt);

  // registered edge strobes, one cycle after the level changes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncLvlQ     <= 1'b0;
      strobe.lead  <= 1'b0;
      strobe.trail <= 1'b0;
    end else begin
      syncLvlQ     <= syncLvl;
      strobe.lead  <= polHighEff ? riseC : fallC;
      strobe.trail <= polHighEff ? fallC : riseC;
    end
  end

  // level-time measurement per line, line boundary = synchronized rise
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      highCnt  <= '0;
      lowCnt   <= '0;
      autoPol  <= 1'b1;
      lastCand <= 1'b1;
    end else if (riseC) begin
      if (lineCand == lastCand) autoPol <= lineCand;
      lastCand <= lineCand;
      highCnt  <= {{(LINE_CNT_W-1){1'b0}}, 1'b1};
      lowCnt   <= '0;
    end else if (syncLvl) begin
      if (highCnt != CNT_MAX) highCnt <= highCnt + 1'b1;
    end else begin
      if (lowCnt != CNT_MAX) lowCnt <= lowCnt + 1'b1;
    end
  end

  assign polDetected = autoPol;
endmodule

// File: rtl/lcs_pulse_dp.sv
module lcs_pulse_dp
  import lcs_pkg::*;
#(
  parameter int CFG_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  edgeStrobe_t      strobe,
  input  logic [CFG_W-1:0] clampPlace,
  input  logic [CFG_W-1:0] clampDur,
  input  logic [CFG_W-1:0] syncWidth,
  input  logic             clampExtSel,
  input  logic             extClampIn,
  output logic             clampOut,
  output logic             syncOut
);
  localparam logic [CFG_W-1:0] ONE = {{(CFG_W-1){1'b0}}, 1'b1};

  logic [CFG_W-1:0] placeQ, durQ, syncLeft, waitCnt, runCnt, placeEff;
  logic selQ, waiting, clampInt;

  assign placeEff = (placeQ == '0) ? ONE : placeQ;

  // regenerated sync width counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncOut  <= 1'b0;
      syncLeft <= '0;
    end else if (strobe.lead) begin
      syncOut  <= (syncWidth != '0);
      syncLeft <= syncWidth - ONE;
    end else if (syncOut) begin
      if (syncLeft == '0) syncOut <= 1'b0;
      else                syncLeft <= syncLeft - ONE;
    end
  end

  // configuration capture and clamp window
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      placeQ   <= '0;
      durQ     <= '0;
      selQ     <= 1'b0;
      waiting  <= 1'b0;
      waitCnt  <= '0;
      clampInt <= 1'b0;
      runCnt   <= '0;
    end else if (strobe.lead) begin
      placeQ   <= clampPlace;
      durQ     <= clampDur;
      selQ     <= clampExtSel;
      waiting  <= 1'b0;
      clampInt <= 1'b0;
    end else if (strobe.trail) begin
      waiting  <= (durQ != '0);
      waitCnt  <= placeEff - ONE;
      clampInt <= 1'b0;
    end else if (waiting) begin
      if (waitCnt == '0) begin
        waiting  <= 1'b0;
        clampInt <= 1'b1;
        runCnt   <= durQ - ONE;
      end else begin
        waitCnt <= waitCnt - ONE;
      end
    end else if (clampInt) begin
      if (runCnt == '0) clampInt <= 1'b0;
      else              runCnt <= runCnt - ONE;
    end
  end

  assign clampOut = selQ ? extClampIn : clampInt;
endmodule

// File: rtl/line_clamp_sync.sv
module line_clamp_sync
  import lcs_pkg::*;
#(
  parameter int CFG_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int LINE_CNT_W  = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hsyncIn,
  input  logic             extClampIn,
  input  logic [CFG_W-1:0] clampPlace,
  input  logic [CFG_W-1:0] clampDur,
  input  logic [CFG_W-1:0] syncWidth,
  input  logic             clampExtSel,
  input  logic             polOverride,
  input  logic             polUser,
  output logic             clampOut,
  output logic             syncOut,
  output logic             polDetected
);
  edgeStrobe_t strobe;
  logic leadStb, trailStb;

  assign leadStb  = strobe.lead;
  assign trailStb = strobe.trail;

  lcs_sync_ctrl #(.SYNC_STAGES(SYNC_STAGES), .LINE_CNT_W(LINE_CNT_W)) ctrl (
    .clk(clk), .rstN(rstN), .hsyncIn(hsyncIn),
    .polOverride(polOverride), .polUser(polUser),
    .strobe(strobe), .polDetected(polDetected)
  );

  lcs_pulse_dp #(.CFG_W(CFG_W)) dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .clampPlace(clampPlace), .clampDur(clampDur), .syncWidth(syncWidth),
    .clampExtSel(clampExtSel), .extClampIn(extClampIn),
    .clampOut(clampOut), .syncOut(syncOut)
  );
endmodule

// File: rtl/lcs_checks.sv
module lcs_checks #(
  parameter int CFG_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             leadStb,
  input logic             trailStb,
  input logic [CFG_W-1:0] clampDur,
  input logic [CFG_W-1:0] syncWidth,
  input logic             clampExtSel,
  input logic             extClampIn,
  input logic             clampOut,
  input logic             syncOut
);
  AST_SYNC_FROM_LEAD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(syncOut) |-> $past(leadStb)); // R1
  AST_SYNC_STARTS: assert property (@(posedge clk) disable iff (!rstN)
    (leadStb && syncWidth != '0) |=> syncOut); // R2
  AST_ZERO_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    (leadStb && syncWidth == '0) |=> !syncOut); // R2
  AST_ZERO_DUR: assert property (@(posedge clk) disable iff (!rstN)
    (leadStb && !clampExtSel && clampDur == '0) |=> !clampOut); // R4
  AST_EXT_FOLLOW: assert property (@(posedge clk) disable iff (!rstN)
    (leadStb && clampExtSel) |=> (clampOut == extClampIn)); // R5
  AST_NO_CLAMP_AT_TRAIL: assert property (@(posedge clk) disable iff (!rstN)
    (trailStb && !leadStb && !clampExtSel && $past(!clampExtSel) && !clampOut) |=> !clampOut); // R3
endmodule

bind line_clamp_sync lcs_checks #(.CFG_W(CFG_W)) chk (
  .clk(clk), .rstN(rstN), .leadStb(leadStb), .trailStb(trailStb),
  .clampDur(clampDur), .syncWidth(syncWidth), .clampExtSel(clampExtSel),
  .extClampIn(extClampIn), .clampOut(clampOut), .syncOut(syncOut)
);

// File: tb/line_clamp_sync_test.sv
`timescale 1ns/1ps
module line_clamp_sync_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hsyncIn = 1'b0, extClampIn = 1'b0;
  logic [7:0] clampPlace = 8'd10, clampDur = 8'd5, syncWidth = 8'd6;
  logic clampExtSel = 1'b0, polOverride = 1'b1, polUser = 1'b1;
  logic clampOut, syncOut, polDetected;

  int checks = 0, errors = 0;
  logic syncLog [0:511];
  logic clampLog [0:511];
  logic extLog [0:511];

  always #5 clk = ~clk;

  line_clamp_sync uut (
    .clk(clk), .rstN(rstN), .hsyncIn(hsyncIn), .extClampIn(extClampIn),
    .clampPlace(clampPlace), .clampDur(clampDur), .syncWidth(syncWidth),
    .clampExtSel(clampExtSel), .polOverride(polOverride), .polUser(polUser),
    .clampOut(clampOut), .syncOut(syncOut), .polDetected(polDetected)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one line: active pulse for pulseLen cycles, then idle; optional mid-line config change
  task automatic runLine(input bit activeHigh, input int pulseLen, input int lineLen,
                         input int chgIdx, input logic [7:0] newPlace, input logic [7:0] newDur);
    if (hsyncIn != !activeHigh) begin
      @(negedge clk);
      hsyncIn = !activeHigh;
      repeat (40) @(negedge clk);
    end
    for (int i = 0; i < lineLen; i++) begin
      @(negedge clk);
      hsyncIn = (i < pulseLen) ? activeHigh : !activeHigh;
      extClampIn = (i % 3 == 0);
      if (i == chgIdx) begin
        clampPlace = newPlace;
        clampDur = newDur;
      end
      #1;
      syncLog[i] = syncOut;
      clampLog[i] = clampOut;
      extLog[i] = extClampIn;
    end
  endtask

  function automatic int countHigh(input bit useClamp, input int lo, input int hi);
    int n = 0;
    for (int i = lo; i <= hi; i++) n += useClamp ? int'(clampLog[i]) : int'(syncLog[i]);
    return n;
  endfunction

  function automatic int firstHigh(input bit useClamp, input int lo, input int hi);
    for (int i = lo; i <= hi; i++) if (useClamp ? clampLog[i] : syncLog[i]) return i;
    return -1;
  endfunction

  task automatic testReset();
    check(syncOut == 1'b0, "R8 syncOut", int'(syncOut), 0);
    check(clampOut == 1'b0, "R8 clampOut", int'(clampOut), 0);
    check(polDetected == 1'b1, "R8 polDetected", int'(polDetected), 1);
  endtask

  task automatic testActiveHigh();
    polOverride = 1; polUser = 1; clampPlace = 10; clampDur = 5; syncWidth = 6;
    runLine(1, 8, 60, -1, 0, 0);
    check(firstHigh(0, 4, 59) == 4, "R1 sync start", firstHigh(0, 4, 59), 4);
    check(countHigh(0, 4, 59) == 6, "R2 sync width", countHigh(0, 4, 59), 6);
    check(firstHigh(1, 4, 59) == 22, "R3 clamp start", firstHigh(1, 4, 59), 22);
    check(countHigh(1, 4, 59) == 5, "R3 clamp length", countHigh(1, 4, 59), 5);
  endtask

  task automatic testActiveLow();
    polOverride = 1; polUser = 0; clampPlace = 3; clampDur = 4; syncWidth = 30;
    runLine(0, 8, 60, -1, 0, 0);
    check(firstHigh(0, 4, 59) == 4, "R6 falling lead", firstHigh(0, 4, 59), 4);
    check(countHigh(0, 4, 59) == 30, "R6 rise starts nothing", countHigh(0, 4, 59), 30);
    check(firstHigh(1, 4, 59) == 15, "R6 clamp from rise", firstHigh(1, 4, 59), 15);
  endtask

  task automatic testPlaceDurEdges();
    polOverride = 1; polUser = 1; clampPlace = 0; clampDur = 3; syncWidth = 6;
    runLine(1, 8, 60, -1, 0, 0);
    check(firstHigh(1, 4, 59) == 13, "R4 place 0 as 1", firstHigh(1, 4, 59), 13);
    check(countHigh(1, 4, 59) == 3, "R4 clamp length", countHigh(1, 4, 59), 3);
    clampPlace = 5; clampDur = 0;
    runLine(1, 8, 60, -1, 0, 0);
    check(countHigh(1, 4, 59) == 0, "R4 dur 0 no clamp", countHigh(1, 4, 59), 0);
    clampDur = 5; syncWidth = 0;
    runLine(1, 8, 60, -1, 0, 0);
    check(countHigh(0, 4, 59) == 0, "R2 width 0 no sync", countHigh(0, 4, 59), 0);
  endtask

  task automatic testExternal();
    int mism = 0;
    polOverride = 1; polUser = 1; clampPlace = 10; clampDur = 5; syncWidth = 6;
    clampExtSel = 1;
    runLine(1, 8, 60, -1, 0, 0);
    for (int i = 4; i < 60; i++) if (clampLog[i] != extLog[i]) mism++;
    check(mism == 0, "R5 clamp follows external", mism, 0);
    clampExtSel = 0;
    runLine(1, 8, 60, -1, 0, 0);
    check(firstHigh(1, 4, 59) == 22, "R5 internal again", firstHigh(1, 4, 59), 22);
    check(countHigh(1, 4, 59) == 5, "R5 internal length", countHigh(1, 4, 59), 5);
  endtask

  task automatic testRestart();
    polOverride = 1; polUser = 1; syncWidth = 50; clampPlace = 2; clampDur = 2;
    runLine(1, 5, 20, -1, 0, 0);
    runLine(1, 5, 80, -1, 0, 0);
    check(countHigh(0, 4, 79) == 50, "R9 restart width", countHigh(0, 4, 79), 50);
    check(syncLog[53] == 1'b1, "R9 last high", int'(syncLog[53]), 1);
    check(syncLog[54] == 1'b0, "R9 ends", int'(syncLog[54]), 0);
  endtask

  task automatic testMidLineChange();
    polOverride = 1; polUser = 1; clampPlace = 10; clampDur = 5; syncWidth = 6;
    runLine(1, 8, 80, 6, 8'd30, 8'd12);
    check(firstHigh(1, 4, 79) == 22, "R10 place held", firstHigh(1, 4, 79), 22);
    check(countHigh(1, 4, 79) == 5, "R10 dur held", countHigh(1, 4, 79), 5);
    clampPlace = 10; clampDur = 5;
  endtask

  task automatic testAuto();
    polOverride = 0; clampPlace = 10; clampDur = 5; syncWidth = 6;
    for (int k = 0; k < 3; k++) runLine(0, 8, 60, -1, 0, 0);
    check(polDetected == 1'b0, "R7 detects active low", int'(polDetected), 0);
    runLine(0, 8, 60, -1, 0, 0);
    check(firstHigh(0, 4, 59) == 4, "R7 auto low lead", firstHigh(0, 4, 59), 4);
    check(countHigh(0, 4, 59) == 6, "R7 auto low width", countHigh(0, 4, 59), 6);
    runLine(1, 8, 60, -1, 0, 0);
    check(polDetected == 1'b0, "R7 one line not enough", int'(polDetected), 0);
    for (int k = 0; k < 3; k++) runLine(1, 8, 60, -1, 0, 0);
    check(polDetected == 1'b1, "R7 detects active high", int'(polDetected), 1);
    runLine(1, 8, 60, -1, 0, 0);
    check(firstHigh(1, 4, 59) == 22, "R7 auto high clamp", firstHigh(1, 4, 59), 22);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    #1;
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    #1;
    testReset();
    testActiveHigh();
    testActiveLow();
    testPlaceDurEdges();
    testExternal();
    testRestart();
    testMidLineChange();
    testAuto();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule